// File: doc/BRIEF.md
# Periodic Loaded-Battery Test Scheduler

This block decides when a backup cell is put under a test load and keeps a latched warning once the cell has been found weak. It counts intervals in timebase ticks from an external tick strobe. After power has been good and the external recovery interval has completed, it runs a test immediately. From then on it runs one test per long interval. When a test fails, the warning is set and testing switches to a short interval, so that a cell swap can be seen quickly. Between tests the block does not look at the cell at all.

Each test turns on the load enable for a fixed number of ticks. The comparator result is sampled on the last tick of that window. Once set, the warning stays set until one of two things happens. The first is a passing test that follows an observed removal of the cell, where the removal lasted at least a minimum detach time. The second is a passing test made on power-up, since a cell may have been swapped while power was off. Whenever power is not good, the block leaves any schedule or test at once. The warning itself survives the outage.

The analog load, the comparator and the cell-presence detector are outside this block. The warning is an open-drain, active-low output, modelled here as a drive-low enable.

Top module: `batt_test_sched`

## Requirements
- R1: After reset the state output is 0 (idle), the load enable is 0 and the warning drive-low enable is 0.
- R2: While the power-good input or the recovery-done input is low, the state is idle (0) from the next cycle on and the load enable is 0, even if a test was running.
- R3: In the cycle after both power-good and recovery-done are high while idle, the state becomes testing (2) with the load enable at 1. The test lasts LOAD_TICKS ticks.
- R4: After a test ends the state is waiting (1) and the load enable is 0. With no warning set, the next test starts after NORMAL_TICKS ticks. The interval counter restarts from zero after every test.
- R5: If the comparator input is low on the last tick of a test window, the warning drive-low enable is 1 from the next cycle on.
- R6: While the warning is set, the waiting interval is WARN_TICKS ticks.
- R7: A passing scheduled test clears the warning only if, since the warning was last set or re-confirmed by a failing test, the presence input has been low for at least DETACH_TICKS consecutive ticks. A shorter detach has no effect.
- R8: A passing power-up test clears the warning unconditionally. After that, waiting intervals return to NORMAL_TICKS.
- R9: The warning keeps its value through power loss and through any cycle that does not end a test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| pwr_good_i | input | 1 | Main supply within tolerance |
| recov_done_i | input | 1 | Power-up recovery interval has elapsed |
| batt_ok_i | input | 1 | Comparator: loaded cell above trip threshold |
| batt_present_i | input | 1 | Cell attached |
| load_en_o | output | 1 | Connect the test load |
| warn_drive_low_o | output | 1 | Pull the active-low warning line low |
| state_o | output | 2 | Scheduler state: 0 idle, 1 waiting, 2 testing |

## Verification
A wrong interval count or a wrong limit selection shows at the ports as a test start moving away from its expected cycle. This becomes visible no later than the end of the current waiting interval. A corrupted warning or detach flag only shows when the next test window closes, as a warning that does not clear, or clears too early. For that reason every outcome is checked in the cycle after a window closes. A stale power-up marker shows the same way: on a passing test without a detach, the warning clears when it should not.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TEST = 2'd2
    } bts_state_e;

    typedef struct packed {
        bts_state_e state;
        logic       pwrup;
    } bts_fsm_t;

    typedef struct packed {
        logic warn;
        logic armed;
    } bts_warn_t;

endpackage

// File: rtl/bts_interval_cnt.sv
module bts_interval_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_end;

    always_comb begin
        at_end = (cnt_q == limit_i - W'(1));
        hit_o  = !clr_i && inc_i && at_end;
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = at_end ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R4: a running count never passes the active limit
    p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && inc_i) |-> (cnt_q < limit_i));

endmodule

// File: rtl/bts_warn_latch.sv
module bts_warn_latch #(
    parameter int DETACH_TICKS = 1,
    localparam int DW = (DETACH_TICKS < 2) ? 1 : $clog2(DETACH_TICKS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic present_i,
    input  logic test_done_i,
    input  logic pass_i,
    input  logic pwrup_i,
    output logic warn_o
);
    import bts_pkg::*;

    bts_warn_t d, q;
    logic      det_clr, det_hit;

    assign det_clr = present_i || !q.warn;

    bts_interval_cnt #(.W(DW)) detach_cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (det_clr),
        .inc_i   (tick_i),
        .limit_i (DW'(DETACH_TICKS)),
        .hit_o   (det_hit)
    );

    always_comb begin
        d = q;
        if (test_done_i) begin
            if (pass_i) d.warn = q.warn && !q.armed && !pwrup_i;
            else        d.warn = 1'b1;
        end
        d.armed = d.warn && !(test_done_i && !pass_i) && (q.armed || det_hit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign warn_o = q.warn;

    // R5: a failed window sets the warning
    p_fail_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_done_i && !pass_i) |=> warn_o);
    // R9: the warning only moves when a window closes
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_done_i |=> $stable(warn_o));
    // R7: without a long detach a scheduled pass keeps the warning
    p_clear_needs_detach_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_done_i && pass_i && !pwrup_i && !q.armed) |=> $stable(warn_o));

endmodule

// File: rtl/bts_sched_fsm.sv
module bts_sched_fsm #(
    parameter int NORMAL_TICKS = 86400,
    parameter int WARN_TICKS   = 5,
    parameter int LOAD_TICKS   = 1,
    parameter int CW           = 17
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          warn_i,
    input  logic          hit_i,
    output logic          cnt_clr_o,
    output logic [CW-1:0] limit_o,
    output logic          test_done_o,
    output logic          pwrup_o,
    output logic [1:0]    state_o
);
    import bts_pkg::*;

    bts_fsm_t d, q;

    always_comb begin
        d           = q;
        test_done_o = 1'b0;
        cnt_clr_o   = !en_i || (q.state == ST_IDLE);
        unique case (q.state)
            ST_IDLE: if (en_i) begin
                d.state = ST_TEST;
                d.pwrup = 1'b1;
            end
            ST_WAIT: if (hit_i) d.state = ST_TEST;
            ST_TEST: if (hit_i) begin
                d.state     = ST_WAIT;
                d.pwrup     = 1'b0;
                test_done_o = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
        if (!en_i) begin
            d.state = ST_IDLE;
            d.pwrup = 1'b0;
        end
    end

    always_comb begin
        if (q.state == ST_TEST) limit_o = CW'(LOAD_TICKS);
        else if (warn_i)        limit_o = CW'(WARN_TICKS);
        else                    limit_o = CW'(NORMAL_TICKS);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: ST_IDLE, pwrup: 1'b0};
        else         q <= d;
    end

    assign pwrup_o = q.pwrup;
    assign state_o = q.state;

    // R3: power-up test starts the cycle after enable while idle
    p_powerup_test_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IDLE && en_i) |=> (q.state == ST_TEST));
    // R4: a wait only ends on a tick
    p_wait_needs_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WAIT && !tick_i) |=> (q.state != ST_TEST));

endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched #(
    parameter int NORMAL_TICKS = 86400,
    parameter int WARN_TICKS   = 5,
    parameter int LOAD_TICKS   = 1,
    parameter int DETACH_TICKS = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       pwr_good_i,
    input  logic       recov_done_i,
    input  logic       batt_ok_i,
    input  logic       batt_present_i,
    output logic       load_en_o,
    output logic       warn_drive_low_o,
    output logic [1:0] state_o
);
    import bts_pkg::*;

    localparam int MAX_A = (NORMAL_TICKS > WARN_TICKS) ? NORMAL_TICKS : WARN_TICKS;
    localparam int MAX_T = (MAX_A > LOAD_TICKS) ? MAX_A : LOAD_TICKS;
    localparam int CW    = $clog2(MAX_T + 1);

    logic          en, cnt_clr, hit, test_done, pwrup, warn;
    logic [CW-1:0] limit;

    assign en = pwr_good_i && recov_done_i;

    bts_interval_cnt #(.W(CW)) period_cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (cnt_clr),
        .inc_i   (tick_i),
        .limit_i (limit),
        .hit_o   (hit)
    );

    bts_sched_fsm #(
        .NORMAL_TICKS (NORMAL_TICKS),
        .WARN_TICKS   (WARN_TICKS),
        .LOAD_TICKS   (LOAD_TICKS),
        .CW           (CW)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en),
        .tick_i      (tick_i),
        .warn_i      (warn),
        .hit_i       (hit),
        .cnt_clr_o   (cnt_clr),
        .limit_o     (limit),
        .test_done_o (test_done),
        .pwrup_o     (pwrup),
        .state_o     (state_o)
    );

    bts_warn_latch #(.DETACH_TICKS(DETACH_TICKS)) warn_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .present_i   (batt_present_i),
        .test_done_i (test_done),
        .pass_i      (batt_ok_i),
        .pwrup_i     (pwrup),
        .warn_o      (warn)
    );

    assign load_en_o        = (state_o == 2'd2);
    assign warn_drive_low_o = warn;

    // R2: loss of power or recovery forces idle on the next cycle
    p_idle_when_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en |=> (state_o == 2'd0 && !load_en_o));

endmodule

// File: tb/batt_test_sched_tb.sv
`timescale 1ns/1ps
module batt_test_sched_tb_top;

    localparam int NP = 20;
    localparam int WP = 6;
    localparam int TL = 3;
    localparam int MD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, pg = 1'b0, rd = 1'b0, ok = 1'b1, present = 1'b1;
    logic load_en, warn_lo;
    logic [1:0] state;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit mc_en = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    batt_test_sched #(
        .NORMAL_TICKS (NP),
        .WARN_TICKS   (WP),
        .LOAD_TICKS   (TL),
        .DETACH_TICKS (MD)
    ) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .tick_i           (tick),
        .pwr_good_i       (pg),
        .recov_done_i     (rd),
        .batt_ok_i        (ok),
        .batt_present_i   (present),
        .load_en_o        (load_en),
        .warn_drive_low_o (warn_lo),
        .state_o          (state)
    );

    // behavioural model from the requirements
    int m_st = 0, m_cnt = 0, m_det = 0;
    bit m_warn = 0, m_armed = 0, m_pu = 0;

    function automatic int lim_of(int st, bit w);
        if (st == 2) return TL;
        return w ? WP : NP;
    endfunction

    task automatic m_step();
        bit en, clr, hit, td, dclr, dhit, wn, an, pun;
        int stn, cn, dn;
        en   = pg && rd;
        clr  = !en || (m_st == 0);
        hit  = !clr && tick && (m_cnt == lim_of(m_st, m_warn) - 1);
        td   = (m_st == 2) && hit;
        cn   = clr ? 0 : (tick ? (hit ? 0 : m_cnt + 1) : m_cnt);
        stn  = m_st;
        pun  = m_pu;
        if (m_st == 0 && en) begin stn = 2; pun = 1; end
        else if (m_st == 1 && hit) stn = 2;
        else if (m_st == 2 && hit) begin stn = 1; pun = 0; end
        if (!en) begin stn = 0; pun = 0; end
        dclr = present || !m_warn;
        dhit = !dclr && tick && (m_det == MD - 1);
        dn   = dclr ? 0 : (tick ? (dhit ? 0 : m_det + 1) : m_det);
        wn   = td ? (ok ? (m_warn && !m_armed && !m_pu) : 1'b1) : m_warn;
        an   = wn && !(td && !ok) && (m_armed || dhit);
        m_st = stn; m_cnt = cn; m_pu = pun; m_det = dn; m_warn = wn; m_armed = an;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_det = 0; m_warn = 0; m_armed = 0; m_pu = 0;
        end else begin
            m_step();
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mc_en) begin
            check(tag, int'(state), m_st, "state vs model");
            check(tag, int'(load_en), (m_st == 2) ? 1 : 0, "load vs model");
            check(tag, int'(warn_lo), int'(m_warn), "warning vs model");
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(int s);
        for (int i = 0; i < 200; i++) begin
            if (int'(state) == s) return;
            @(negedge clk);
        end
        check(tag, int'(state), s, "state reached");
    endtask

    function automatic int span_of(int s);
        return s;
    endfunction

    task automatic measure(int s, string req, int exp);
        int n = 0;
        while (int'(state) == s && n < 200) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp, "cycles spent in state");
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        cyc(3);
        check("R1", int'(state), 0, "state after reset");
        check("R1", int'(load_en), 0, "load after reset");
        check("R1", int'(warn_lo), 0, "warning after reset");
        rst_n = 1'b1;
        tick  = 1'b1;
        mc_en = 1'b1;

        tag = "R2";
        pg = 1'b1;
        cyc(10);
        check("R2", int'(state), 0, "idle until recovery done");

        tag = "R3";
        rd = 1'b1;
        cyc(1);
        check("R3", int'(state), 2, "power-up test started");
        check("R3", int'(load_en), 1, "load on in test");
        measure(2, "R3", TL);

        tag = "R4";
        check("R4", int'(load_en), 0, "load off while waiting");
        measure(1, "R4", NP);

        tag = "R5";
        ok = 1'b0;
        wait_state(1);
        check("R5", int'(warn_lo), 1, "warning after failed window");

        tag = "R6";
        measure(1, "R6", WP);

        tag = "R7";
        wait_state(1);
        ok = 1'b1;
        present = 1'b0;
        cyc(2);
        present = 1'b1;
        wait_state(2);
        wait_state(1);
        check("R7", int'(warn_lo), 1, "short detach keeps warning");
        present = 1'b0;
        cyc(5);
        present = 1'b1;
        wait_state(2);
        wait_state(1);
        check("R7", int'(warn_lo), 0, "long detach then pass clears");
        measure(1, "R4", NP);

        tag = "R9";
        ok = 1'b0;
        wait_state(1);
        check("R5", int'(warn_lo), 1, "warning set again");
        ok = 1'b1;
        pg = 1'b0;
        cyc(1);
        check("R2", int'(state), 0, "power loss forces idle");
        cyc(5);
        check("R9", int'(warn_lo), 1, "warning survives power loss");

        tag = "R8";
        pg = 1'b1;
        cyc(1);
        check("R8", int'(state), 2, "test on power return");
        wait_state(1);
        check("R8", int'(warn_lo), 0, "power-up pass clears warning");
        measure(1, "R8", NP);

        tag = "R2/R4/R5/R6/R7/R9";
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 2) == 0;
            if ($urandom % 150 == 0) pg = ~pg;
            rd = pg && ($urandom % 10 != 0);
            if ($urandom % 25 == 0) ok = ~ok;
            if ($urandom % 30 == 0) present = ~present;
            cyc(1);
        end
        finish_run();
    end

endmodule